// File: doc/BRIEF.md
# E-paper panel timing generator

This block produces the line and frame timing for an electrophoretic panel. The panel is driven through a source-driver bus and a gate-driver shift chain. A horizontal counter steps once per source-clock tick and a vertical counter steps once per completed line. Both counters run between boundaries given as four lengths for each axis: sync, begin, data and end.

From the two counters the block decodes the following strobes:
- line sync and frame sync;
- the horizontal and vertical active windows, and their product, the data-enable strobe;
- the gate-driver clock pulse;
- the source chip-enable window.

The source-clock tick is derived inside the block from the system clock. It divides by 4 for the narrow (8-bit) bus and by 8 for the wide (16-bit) bus.

A rising edge on `start` begins an update run. A run lasts a programmed number of frames, given as frames minus one. A frame-end pulse is raised after every frame. A single display-end pulse is raised after the last frame, and the block then returns to idle. A line-flag pulse marks entry into a chosen line number.

Top module: `eink_timing_gen`

## Requirements
- R1: A line lasts hs+hb+hd+he source ticks, with the horizontal count running 0 to that total minus one. `line_sync` is high while the horizontal count is below hs.
- R2: `h_active` is high for horizontal counts from hs+hb up to, but not including, hs+hb+hd.
- R3: A frame lasts vs+vb+vd+ve lines. `frame_sync` is high on lines below vs. `v_active` is high on lines from vs+vb up to, but not including, vs+vb+vd. `data_en` is high exactly when both `h_active` and `v_active` are high.
- R4: `gate_clk` rises at horizontal count `gate_rise` and falls at horizontal count `gate_fall`. Both counts are measured from count 0, where `line_sync` rises.
- R5: `src_ce` is high on active lines for a window that starts at horizontal count hs+hb and lasts `ce_width` ticks. When `ce_width` is 0, the window lasts hd ticks instead.
- R6: After an accepted start, exactly `frame_total_m1`+1 frames run, and `frame_end_evt` pulses for one clock after each of them.
- R7: `disp_end_evt` pulses once, in the same clock as the last frame's `frame_end_evt`. `busy` is low from that clock on.
- R8: A start is accepted only on a 0-to-1 change of `start`. A `start` held high through and after reset starts nothing until it has been seen low.
- R9: A rising `start` while `busy` is high is ignored and does not disturb the timing of the run.
- R10: While idle, or after reset, `busy` and every strobe and event output are low. Reset during a run returns the block to idle in the next clock.
- R11: `line_flag_evt` pulses for one clock when the line count advances into line `flag_line`. This includes the wrap to line 0 between frames of a run, but not the run's first line, nor the wrap after the last frame.
- R12: `src_tick` pulses once every 4 clocks when `wide_mode` is 0, and once every 8 clocks when it is 1. The mode is sampled when the run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, acted on at its rising edge |
| wide_mode | input | 1 | 1 selects the 16-bit bus (tick every 8 clocks), 0 the 8-bit bus (every 4) |
| hs_len | input | 12 | Line sync length in ticks |
| hb_len | input | 12 | Line begin (back porch) length |
| hd_len | input | 12 | Line data length |
| he_len | input | 12 | Line end length |
| vs_len | input | 11 | Frame sync length in lines |
| vb_len | input | 11 | Frame begin length |
| vd_len | input | 11 | Frame data length |
| ve_len | input | 11 | Frame end length |
| gate_rise | input | 12 | Horizontal count where the gate clock rises |
| gate_fall | input | 12 | Horizontal count where the gate clock falls |
| ce_width | input | 12 | Chip-enable window width, 0 = use data length |
| frame_total_m1 | input | 8 | Frames per run minus one |
| flag_line | input | 11 | Line number that raises the line flag |
| busy | output | 1 | A run is in progress |
| src_tick | output | 1 | Source-clock tick strobe |
| line_sync | output | 1 | Line sync |
| frame_sync | output | 1 | Frame sync |
| h_active | output | 1 | Horizontal active window |
| v_active | output | 1 | Vertical active window |
| data_en | output | 1 | Active pixel window |
| gate_clk | output | 1 | Gate-driver clock |
| src_ce | output | 1 | Source chip-enable window |
| frame_end_evt | output | 1 | One-clock pulse after each frame |
| disp_end_evt | output | 1 | One-clock pulse after the last frame of a run |
| line_flag_evt | output | 1 | One-clock pulse on entering the flagged line |

## Verification
A bad horizontal count first shows up in `line_sync`, `gate_clk` or `h_active`, one tick after the count goes wrong, so within 4 or 8 clocks. A bad line or frame count stays hidden until the next line boundary, or until the end of the run. There it moves `frame_sync`, `v_active`, `line_flag_evt` or the frame and display-end pulses.

The bench therefore compares every output on every clock against a model computed from the requirements. It also counts the end pulses of each run, so that an error in frame counting is caught at the end of the run.

// File: rtl/eink_tg_pkg.sv
package eink_tg_pkg;

    localparam int TG_HW          = 12;
    localparam int TG_VW          = 11;
    localparam int TG_FW          = 8;
    localparam int TG_DIV_NARROW  = 4;
    localparam int TG_DIV_WIDE    = 8;

    typedef enum logic {
        TG_IDLE = 1'b0,
        TG_RUN  = 1'b1
    } tg_state_e;

    typedef struct packed {
        logic frame_end;
        logic disp_end;
        logic line_flag;
    } tg_evt_t;

    // half-open window test: lo <= cnt < hi
    function automatic logic in_window(input logic [31:0] cnt,
                                       input logic [31:0] lo,
                                       input logic [31:0] hi);
        return (cnt >= lo) && (cnt < hi);
    endfunction

endpackage

// File: rtl/eink_tick_gen.sv
module eink_tick_gen
    import eink_tg_pkg::*;
#(
    parameter int NARROW_DIV = TG_DIV_NARROW,
    parameter int WIDE_DIV   = TG_DIV_WIDE
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wide,
    output logic tick
);
    localparam int CW = $clog2(WIDE_DIV);

    logic [CW-1:0] cnt;
    logic          wide_q;
    logic [CW-1:0] lim_m1;

    assign lim_m1 = wide_q ? CW'(WIDE_DIV - 1) : CW'(NARROW_DIV - 1);
    assign tick   = run && (cnt == lim_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            wide_q <= 1'b0;
        end else if (!run) begin
            cnt    <= '0;
            wide_q <= wide;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // R12: ticks never come back to back
    a_r12_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/eink_line_ctr.sv
module eink_line_ctr
    import eink_tg_pkg::*;
#(
    parameter int HW = TG_HW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [HW-1:0] hs,
    input  logic [HW-1:0] hb,
    input  logic [HW-1:0] hd,
    input  logic [HW-1:0] he,
    input  logic [HW-1:0] g_rise,
    input  logic [HW-1:0] g_fall,
    input  logic [HW-1:0] ce_w,
    output logic          line_last,
    output logic          line_sync,
    output logic          h_active,
    output logic          gate_clk,
    output logic          ce_hwin
);
    localparam int SW = HW + 2;

    logic [SW-1:0] hcnt;
    logic [SW-1:0] htot, act_st, act_end, ce_len, ce_end;

    always_comb begin
        htot    = SW'(hs) + SW'(hb) + SW'(hd) + SW'(he);
        act_st  = SW'(hs) + SW'(hb);
        act_end = act_st + SW'(hd);
        ce_len  = (ce_w == '0) ? SW'(hd) : SW'(ce_w);
        ce_end  = act_st + ce_len;
    end

    assign line_last = (hcnt == htot - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
        end else if (tick) begin
            hcnt <= line_last ? '0 : hcnt + 1'b1;
        end
    end

    assign line_sync = run && (hcnt < SW'(hs));
    assign h_active  = run && in_window(32'(hcnt), 32'(act_st), 32'(act_end));
    assign gate_clk  = run && in_window(32'(hcnt), 32'(g_rise), 32'(g_fall));
    assign ce_hwin   = run && in_window(32'(hcnt), 32'(act_st), 32'(ce_end));

    // R10: count parked at zero whenever no run is in progress
    a_r10_idle_hzero: assert property (@(posedge clk) disable iff (rst)
        !run |=> (hcnt == '0));

    // R2: active window never overlaps the sync pulse
    a_r2_hact_no_sync: assert property (@(posedge clk) disable iff (rst)
        h_active |-> !line_sync);

endmodule

// File: rtl/eink_frame_ctl.sv
module eink_frame_ctl
    import eink_tg_pkg::*;
#(
    parameter int VW = TG_VW,
    parameter int FW = TG_FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          line_end,
    input  logic [VW-1:0] vs,
    input  logic [VW-1:0] vb,
    input  logic [VW-1:0] vd,
    input  logic [VW-1:0] ve,
    input  logic [FW-1:0] frames_m1,
    input  logic [VW-1:0] flag_line,
    output logic          busy,
    output logic          frame_sync,
    output logic          v_active,
    output tg_evt_t       evt
);
    localparam int SW = VW + 2;

    tg_state_e     state;
    logic [SW-1:0] vcnt, v_next;
    logic [FW-1:0] frm;
    logic          start_q;
    logic [SW-1:0] vtot, act_st, act_end;
    logic          rise, vlast, frame_done, run_done, flag_hit;

    always_comb begin
        vtot    = SW'(vs) + SW'(vb) + SW'(vd) + SW'(ve);
        act_st  = SW'(vs) + SW'(vb);
        act_end = act_st + SW'(vd);
    end

    assign busy       = (state == TG_RUN);
    assign rise       = start && !start_q;
    assign vlast      = (vcnt == vtot - 1'b1);
    assign v_next     = vlast ? '0 : vcnt + 1'b1;
    assign frame_done = busy && line_end && vlast;
    assign run_done   = frame_done && (frm == frames_m1);
    assign flag_hit   = busy && line_end && !run_done && (v_next == SW'(flag_line));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TG_IDLE;
            vcnt    <= '0;
            frm     <= '0;
            start_q <= 1'b1;
            evt     <= '0;
        end else begin
            start_q <= start;
            evt     <= '{frame_end: frame_done, disp_end: run_done, line_flag: flag_hit};
            case (state)
                TG_IDLE: begin
                    vcnt <= '0;
                    frm  <= '0;
                    if (rise) state <= TG_RUN;
                end
                default: begin
                    if (line_end)   vcnt <= v_next;
                    if (frame_done) frm  <= frm + 1'b1;
                    if (run_done) begin
                        state <= TG_IDLE;
                        vcnt  <= '0;
                        frm   <= '0;
                    end
                end
            endcase
        end
    end

    assign frame_sync = busy && (vcnt < SW'(vs));
    assign v_active   = busy && in_window(32'(vcnt), 32'(act_st), 32'(act_end));

    // R7: display end leaves the block idle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        evt.disp_end |-> !busy);

    // R7: display end coincides with a frame end
    a_r7_done_with_frame: assert property (@(posedge clk) disable iff (rst)
        evt.disp_end |-> evt.frame_end);

    // R9: a run only stops at a line boundary, never on a new start
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !line_end) |=> busy);

    // R11: line flag never fires in the same clock as display end
    a_r11_flag_not_end: assert property (@(posedge clk) disable iff (rst)
        evt.line_flag |-> !evt.disp_end);

endmodule

// File: rtl/eink_timing_gen.sv
module eink_timing_gen
    import eink_tg_pkg::*;
#(
    parameter int HW = TG_HW,
    parameter int VW = TG_VW,
    parameter int FW = TG_FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          wide_mode,
    input  logic [HW-1:0] hs_len,
    input  logic [HW-1:0] hb_len,
    input  logic [HW-1:0] hd_len,
    input  logic [HW-1:0] he_len,
    input  logic [VW-1:0] vs_len,
    input  logic [VW-1:0] vb_len,
    input  logic [VW-1:0] vd_len,
    input  logic [VW-1:0] ve_len,
    input  logic [HW-1:0] gate_rise,
    input  logic [HW-1:0] gate_fall,
    input  logic [HW-1:0] ce_width,
    input  logic [FW-1:0] frame_total_m1,
    input  logic [VW-1:0] flag_line,
    output logic          busy,
    output logic          src_tick,
    output logic          line_sync,
    output logic          frame_sync,
    output logic          h_active,
    output logic          v_active,
    output logic          data_en,
    output logic          gate_clk,
    output logic          src_ce,
    output logic          frame_end_evt,
    output logic          disp_end_evt,
    output logic          line_flag_evt
);
    logic    line_last, line_end, ce_hwin;
    tg_evt_t evt;

    eink_tick_gen u_tick (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .wide(wide_mode),
        .tick(src_tick)
    );

    eink_line_ctr #(.HW(HW)) u_line (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .tick     (src_tick),
        .hs       (hs_len),
        .hb       (hb_len),
        .hd       (hd_len),
        .he       (he_len),
        .g_rise   (gate_rise),
        .g_fall   (gate_fall),
        .ce_w     (ce_width),
        .line_last(line_last),
        .line_sync(line_sync),
        .h_active (h_active),
        .gate_clk (gate_clk),
        .ce_hwin  (ce_hwin)
    );

    assign line_end = src_tick && line_last;

    eink_frame_ctl #(.VW(VW), .FW(FW)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .line_end  (line_end),
        .vs        (vs_len),
        .vb        (vb_len),
        .vd        (vd_len),
        .ve        (ve_len),
        .frames_m1 (frame_total_m1),
        .flag_line (flag_line),
        .busy      (busy),
        .frame_sync(frame_sync),
        .v_active  (v_active),
        .evt       (evt)
    );

    assign data_en       = h_active && v_active;
    assign src_ce        = ce_hwin && v_active;
    assign frame_end_evt = evt.frame_end;
    assign disp_end_evt  = evt.disp_end;
    assign line_flag_evt = evt.line_flag;

    // R10: no strobe while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(line_sync || frame_sync || gate_clk || src_ce || data_en || src_tick));

endmodule

// File: tb/eink_timing_gen_tb.sv
module eink_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic [11:0] hs_len = '0, hb_len = '0, hd_len = '0, he_len = '0;
    logic [10:0] vs_len = '0, vb_len = '0, vd_len = '0, ve_len = '0;
    logic [11:0] gate_rise = '0, gate_fall = '0, ce_width = '0;
    logic [7:0]  frame_total_m1 = '0;
    logic [10:0] flag_line = '0;
    logic busy, src_tick, line_sync, frame_sync, h_active, v_active, data_en;
    logic gate_clk, src_ce, frame_end_evt, disp_end_evt, line_flag_evt;

    eink_timing_gen u_dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0, failures = 0, cyc_total = 0;

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc_total);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // columns: hs hb hd he vs vb vd ve grise gfall cew fm1 flag wide restart
    localparam int NCFG = 4;
    localparam int CFG [NCFG][15] = '{
        '{2, 2, 4, 2, 1, 1, 2, 1, 1, 5, 0, 1, 3, 0,  50},
        '{1, 3, 5, 1, 2, 1, 3, 1, 0, 3, 3, 2, 0, 0, 300},
        '{3, 1, 6, 2, 1, 2, 2, 2, 2, 9, 0, 0, 6, 1,   0},
        '{1, 1, 3, 1, 1, 1, 1, 1, 1, 2, 5, 3, 1, 1, 100}
    };

    // reference model state
    int mb, md, mh, mv, mf, mw, msq, m_fe, m_de, m_lf;
    int err [12];
    string nm [12] = '{"R9 R10 busy", "R12 src_tick", "R1 line_sync", "R3 frame_sync",
                       "R2 h_active", "R3 v_active", "R3 data_en", "R4 gate_clk",
                       "R5 src_ce", "R6 frame_end_evt", "R7 disp_end_evt", "R11 line_flag_evt"};

    task automatic load_cfg(input int i);
        hs_len = 12'(CFG[i][0]); hb_len = 12'(CFG[i][1]);
        hd_len = 12'(CFG[i][2]); he_len = 12'(CFG[i][3]);
        vs_len = 11'(CFG[i][4]); vb_len = 11'(CFG[i][5]);
        vd_len = 11'(CFG[i][6]); ve_len = 11'(CFG[i][7]);
        gate_rise = 12'(CFG[i][8]); gate_fall = 12'(CFG[i][9]);
        ce_width = 12'(CFG[i][10]); frame_total_m1 = 8'(CFG[i][11]);
        flag_line = 11'(CFG[i][12]); wide_mode = CFG[i][13][0];
    endtask

    task automatic compare(input int i);
        int hs, hb, hd, vs, vb, vd, w, lim;
        bit e [12];
        bit a [12];
        hs = CFG[i][0]; hb = CFG[i][1]; hd = CFG[i][2];
        vs = CFG[i][4]; vb = CFG[i][5]; vd = CFG[i][6];
        w   = (CFG[i][10] == 0) ? hd : CFG[i][10];
        lim = (mw != 0) ? 8 : 4;
        e[0]  = mb != 0;
        e[1]  = (mb != 0) && md == lim - 1;
        e[2]  = (mb != 0) && mh < hs;
        e[3]  = (mb != 0) && mv < vs;
        e[4]  = (mb != 0) && mh >= hs + hb && mh < hs + hb + hd;
        e[5]  = (mb != 0) && mv >= vs + vb && mv < vs + vb + vd;
        e[6]  = e[4] && e[5];
        e[7]  = (mb != 0) && mh >= CFG[i][8] && mh < CFG[i][9];
        e[8]  = e[5] && mh >= hs + hb && mh < hs + hb + w;
        e[9]  = m_fe != 0;
        e[10] = m_de != 0;
        e[11] = m_lf != 0;
        a = '{busy, src_tick, line_sync, frame_sync, h_active, v_active, data_en,
              gate_clk, src_ce, frame_end_evt, disp_end_evt, line_flag_evt};
        for (int k = 0; k < 12; k++) if (a[k] != e[k]) err[k]++;
    endtask

    task automatic step(input int i, input bit st);
        int ht, vt, lim, nv;
        bit tick, hl, vl, le, fe, de, rise;
        ht  = CFG[i][0] + CFG[i][1] + CFG[i][2] + CFG[i][3];
        vt  = CFG[i][4] + CFG[i][5] + CFG[i][6] + CFG[i][7];
        lim = (mw != 0) ? 8 : 4;
        tick = (mb != 0) && md == lim - 1;
        hl = mh == ht - 1; vl = mv == vt - 1;
        le = tick && hl; fe = le && vl; de = fe && mf == CFG[i][11];
        nv = vl ? 0 : mv + 1;
        rise = st && (msq == 0);
        msq = st;
        m_fe = fe; m_de = de; m_lf = (le && !de && nv == CFG[i][12]) ? 1 : 0;
        if (mb == 0) begin
            mw = wide_mode; md = 0; mh = 0; mv = 0; mf = 0;
            if (rise) mb = 1;
        end else begin
            md = tick ? 0 : md + 1;
            if (tick) mh = hl ? 0 : mh + 1;
            if (le) mv = nv;
            if (fe) mf++;
            if (de) begin mb = 0; mf = 0; end
        end
    endtask

    task automatic run_cfg(input int i);
        int n, fe_cnt, de_cnt, rs;
        bit st;
        load_cfg(i);
        mb = 0; md = 0; mh = 0; mv = 0; mf = 0; mw = 0; msq = 0;
        m_fe = 0; m_de = 0; m_lf = 0;
        for (int k = 0; k < 12; k++) err[k] = 0;
        fe_cnt = 0; de_cnt = 0; rs = CFG[i][14];
        n = (CFG[i][11] + 1) * (CFG[i][0] + CFG[i][1] + CFG[i][2] + CFG[i][3])
            * (CFG[i][4] + CFG[i][5] + CFG[i][6] + CFG[i][7]) * (CFG[i][13] != 0 ? 8 : 4) + 20;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare(i);
            if (frame_end_evt) fe_cnt++;
            if (disp_end_evt) de_cnt++;
            st = (c == 1 || c == 2) || (rs > 0 && (c == rs || c == rs + 1));
            start = st;
            step(i, st);
        end
        start = 1'b0;
        for (int k = 0; k < 12; k++)
            check(err[k] == 0, $sformatf("%s cfg%0d mismatching clocks", nm[k], i), err[k], 0);
        check(fe_cnt == CFG[i][11] + 1, $sformatf("R6 frame_end count cfg%0d", i), fe_cnt, CFG[i][11] + 1);
        check(de_cnt == 1, $sformatf("R7 disp_end count cfg%0d", i), de_cnt, 1);
    endtask

    initial begin
        int guard;
        load_cfg(0);
        start = 1'b1;                       // held high through reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check(busy == 1'b0, "R8 start held through reset ignored", busy, 0);
        check({line_sync, frame_sync, gate_clk, src_ce, data_en, src_tick,
               frame_end_evt, disp_end_evt, line_flag_evt} == '0,
              "R10 idle strobes after reset", 0, 0);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R8 rising start accepted", busy, 1);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R10 reset mid-run busy", busy, 0);
        check({line_sync, frame_sync, gate_clk, src_ce, h_active, v_active} == '0,
              "R10 reset mid-run strobes", 0, 0);
        rst = 1'b0;
        @(negedge clk);
        // the same config now runs to completion from a clean start
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (busy && guard < 5000) begin @(negedge clk); guard++; end
        check(busy == 1'b0, "R7 run reaches idle", busy, 0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < NCFG; i++) begin
            run_cfg(i);
            repeat (4) @(negedge clk);
        end
        summary();
        $finish;
    end
endmodule